// File: doc/BRIEF.md
# Page Protection and Fault Prioritizer

This block sits behind a translation lookaside buffer. Each cycle with `req_valid` high it receives the TLB lookup result for one virtual address, the kind of access being attempted, the current privilege level and two mode flags. One cycle later it returns the physical address, the permission mask that may be cached for later accesses to the page, and a 4-bit fault code.

Permissions are formed from a 3-bit rights type and two privilege bounds held in the entry. The entry's dirty, break and reference bits then raise faults in a fixed priority, and they also remove permission bits, so that a later access re-checks the entry. When a fault is reported and capture is enabled, the faulting virtual address is split into an offset register (low 32 bits) and a space register (the bits above), which a trap handler can read.

A probe mode serves address-translation queries. In that mode a miss is reported with its own code, so that software can tell a query miss from a real access miss.

Top module: `page_guard`

## Requirements
- R1: With `phys_mode` high, `pa` equals the low `PA_W` bits of `vaddr`, `perm` is 3'b111 and `fault` is 0, whatever the other inputs are.
- R2: Outside physical mode, when `hit` is 0 or `ent_valid` is 0, `fault` is 1 (data TLB miss) for every access type, including execute (`acc_type` 2'b11), and `pa` and `perm` are both 0.
- R3: On a valid hit, `pa` is `{ent_ppn, vaddr[11:0]}`.
- R4: The permission mask uses bit 0 for read, bit 1 for write and bit 2 for execute. Privilege 0 is the most privileged. Read requires `priv <= ent_pl1`. Write requires `priv <= ent_pl2`. Execute requires `ent_pl2 <= priv <= ent_pl1`.
- R5: `ent_type` grants: 0 read only, 1 read and write, 2 read and execute, 3 read, write and execute, 4 to 7 execute only. Each grant is further limited by R4.
- R6: `acc_type` 2'b00 (none) returns the translation and the R4/R5 mask unchanged, with `fault` 0, even when D is clear or B or T is set.
- R7: `acc_type` encodes 01 read, 10 write and 11 execute. When the requested bit is missing from the mask, `fault` is 3 (instruction protection) for execute. Otherwise it is 4 (data protection) if read is granted, and 5 (data access rights) if read is not granted. In this case the mask is returned unstripped.
- R8: When permission is present, these rules apply in order, and a later rule overrides an earlier one: D clear on a write gives 6 (dirty), B set on a write gives 7 (break), T set on a read or write gives 8 (page reference).
- R9: When permission is present, D clear or B set removes the write bit from `perm`, and T set leaves only the execute bit, for every access type except none.
- R10: On a response with nonzero `fault` whose request had `capture_en` high, `ior` takes `vaddr[31:0]` and `isr` takes `vaddr[63:32]`. In all other cases both registers keep their value. Both reset to 0.
- R11: With `probe_mode` high, a miss reports `fault` 2 (non-access data TLB miss) instead of 1.
- R12: `rsp_valid` and the results appear on the clock edge after the request is presented. `rsp_valid` is low after reset and in any cycle that follows a cycle with `req_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| phys_mode | input | 1 | Translation disabled |
| probe_mode | input | 1 | Translation query; miss reported as non-access |
| capture_en | input | 1 | Allow fault address capture |
| acc_type | input | 2 | 00 none, 01 read, 10 write, 11 execute |
| priv | input | 2 | Current privilege level, 0 highest |
| vaddr | input | VA_W (64) | Virtual address |
| hit | input | 1 | TLB lookup matched |
| ent_valid | input | 1 | Matched entry is valid |
| ent_ppn | input | PPN_W (20) | Physical page number |
| ent_pl1 | input | 2 | Read / execute upper privilege bound |
| ent_pl2 | input | 2 | Write bound / execute lower bound |
| ent_type | input | 3 | Rights type |
| ent_d | input | 1 | Dirty bit |
| ent_b | input | 1 | Break bit |
| ent_t | input | 1 | Reference-trap bit |
| rsp_valid | output | 1 | Result valid |
| pa | output | PA_W (32) | Physical address |
| perm | output | 3 | Permission mask {x, w, r} |
| fault | output | 4 | Fault code, 0 none |
| ior | output | 32 | Captured fault offset |
| isr | output | VA_W-32 (32) | Captured fault space |

## Verification
The bench goes after the override order by setting D clear, B set and T set together on a write. A design that checks the rules in forward order would report dirty where a page-reference fault belongs. Miss on an instruction fetch and miss in probe mode are driven on purpose. Wrong handling shows up either as an instruction fault code or as the plain miss code. Accesses of type none with every bit set would expose a design that strips the mask or faults when it should bypass. Privilege values at the window edges would expose an off-by-one comparison in the execute window. Capture is checked both on faults with capture disabled and on clean accesses, so a register that updates on the wrong condition is caught.

// File: rtl/pg_pkg.sv
// Shared encodings for the page protection block.
// Assumes permission bit order {exec, write, read}.
package pg_pkg;
    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_EXEC  = 2'b11
    } acc_e;

    typedef enum logic [3:0] {
        FLT_NONE     = 4'd0,
        FLT_MISS     = 4'd1,
        FLT_NA_MISS  = 4'd2,
        FLT_INST_PROT = 4'd3,
        FLT_DATA_PROT = 4'd4,
        FLT_DATA_AR  = 4'd5,
        FLT_DIRTY    = 4'd6,
        FLT_BREAK    = 4'd7,
        FLT_PAGE_REF = 4'd8
    } fault_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;
endpackage

// File: rtl/pg_rights.sv
// Combinational rights decoder: turns an entry's rights type and its two
// privilege bounds into a {x,w,r} mask for the current privilege level.
// Assumes lower privilege numbers are more privileged.
module pg_rights
    import pg_pkg::*;
#(
    parameter int PL_W = 2,
    parameter int TYPE_W = 3
) (
    input  logic [PL_W-1:0]   priv,
    input  logic [PL_W-1:0]   pl1,
    input  logic [PL_W-1:0]   pl2,
    input  logic [TYPE_W-1:0] rtype,
    output logic [2:0]        mask
);
    logic can_r, can_w, can_x;

    // Privilege tests against the entry bounds.
    always_comb begin
        can_r = (priv <= pl1);
        can_w = (priv <= pl2);
        can_x = (pl2 <= priv) && (priv <= pl1);
    end

    // Type encoding selects which tests contribute to the mask.
    always_comb begin
        mask = 3'b000;
        if (rtype[TYPE_W-1:2] != '0) begin
            mask[PERM_X] = can_x;
        end else begin
            mask[PERM_R] = can_r;
            mask[PERM_W] = rtype[0] & can_w;
            mask[PERM_X] = rtype[1] & can_x;
        end
    end
endmodule

// File: rtl/pg_fault.sv
// Fault resolver for a valid hit: decides a protection fault, or applies the
// dirty, break and reference rules lowest priority first so the last
// matching rule wins, stripping permission bits as it goes.
module pg_fault
    import pg_pkg::*;
(
    input  acc_e        acc,
    input  logic [2:0]  base_mask,
    input  logic        bit_d,
    input  logic        bit_b,
    input  logic        bit_t,
    output logic [2:0]  out_mask,
    output fault_e      out_fault
);
    logic [2:0] want;
    logic       is_wr, is_ex;

    // Requested permission bit from the access type.
    always_comb begin
        is_wr = (acc == ACC_WRITE);
        is_ex = (acc == ACC_EXEC);
        unique case (acc)
            ACC_READ:  want = 3'b001;
            ACC_WRITE: want = 3'b010;
            ACC_EXEC:  want = 3'b100;
            default:   want = 3'b000;
        endcase
    end

    // Protection check, then the ordered bit rules.
    always_comb begin
        out_mask  = base_mask;
        out_fault = FLT_NONE;
        if (acc == ACC_NONE) begin
            out_fault = FLT_NONE;
        end else if ((base_mask & want) == 3'b000) begin
            if (is_ex)                  out_fault = FLT_INST_PROT;
            else if (base_mask[PERM_R]) out_fault = FLT_DATA_PROT;
            else                        out_fault = FLT_DATA_AR;
        end else begin
            if (!bit_d) begin
                if (is_wr) out_fault = FLT_DIRTY;
                out_mask[PERM_W] = 1'b0;
            end
            if (bit_b) begin
                if (is_wr) out_fault = FLT_BREAK;
                out_mask[PERM_W] = 1'b0;
            end
            if (bit_t) begin
                if (!is_ex) out_fault = FLT_PAGE_REF;
                out_mask = out_mask & 3'b100;
            end
        end
    end
endmodule

// File: rtl/pg_capture.sv
// Fault address capture: on a faulting request with capture enabled, stores
// the offset and space halves of the virtual address; otherwise holds.
module pg_capture #(
    parameter int VA_W = 64,
    parameter int OFF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [VA_W-1:0]       addr,
    output logic [OFF_W-1:0]      off_q,
    output logic [VA_W-OFF_W-1:0] spc_q
);
    // Load both halves together on a qualifying fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            spc_q <= '0;
        end else if (load) begin
            off_q <= addr[OFF_W-1:0];
            spc_q <= addr[VA_W-1:OFF_W];
        end
    end

    assert_capture_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> off_q == $past(addr[OFF_W-1:0]) && spc_q == $past(addr[VA_W-1:OFF_W]));
    assert_capture_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) && $past(rst_n) |-> $stable(off_q) && $stable(spc_q));
endmodule

// File: rtl/page_guard.sv
// Top: per-request permission and fault evaluation behind a TLB lookup.
// Assumes the lookup result is presented together with the request and that
// PA_W does not exceed VA_W. All results are registered once.
module page_guard
    import pg_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PPN_W = 20,
    parameter int PAGE_BITS = 12,
    parameter int OFF_W = 32,
    localparam int PA_W = PPN_W + PAGE_BITS,
    localparam int SPC_W = VA_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              phys_mode,
    input  logic              probe_mode,
    input  logic              capture_en,
    input  logic [1:0]        acc_type,
    input  logic [1:0]        priv,
    input  logic [VA_W-1:0]   vaddr,
    input  logic              hit,
    input  logic              ent_valid,
    input  logic [PPN_W-1:0]  ent_ppn,
    input  logic [1:0]        ent_pl1,
    input  logic [1:0]        ent_pl2,
    input  logic [2:0]        ent_type,
    input  logic              ent_d,
    input  logic              ent_b,
    input  logic              ent_t,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   pa,
    output logic [2:0]        perm,
    output logic [3:0]        fault,
    output logic [OFF_W-1:0]  ior,
    output logic [SPC_W-1:0]  isr
);
    logic [2:0]      rights_mask, hit_mask, nxt_perm;
    fault_e          hit_fault, nxt_fault;
    logic [PA_W-1:0] nxt_pa;

    pg_rights #(.PL_W(2), .TYPE_W(3)) u_rights (
        .priv  (priv),
        .pl1   (ent_pl1),
        .pl2   (ent_pl2),
        .rtype (ent_type),
        .mask  (rights_mask)
    );

    pg_fault u_fault (
        .acc       (acc_e'(acc_type)),
        .base_mask (rights_mask),
        .bit_d     (ent_d),
        .bit_b     (ent_b),
        .bit_t     (ent_t),
        .out_mask  (hit_mask),
        .out_fault (hit_fault)
    );

    // Select between physical, miss and hit results.
    always_comb begin
        if (phys_mode) begin
            nxt_pa    = vaddr[PA_W-1:0];
            nxt_perm  = 3'b111;
            nxt_fault = FLT_NONE;
        end else if (!hit || !ent_valid) begin
            nxt_pa    = '0;
            nxt_perm  = 3'b000;
            nxt_fault = probe_mode ? FLT_NA_MISS : FLT_MISS;
        end else begin
            nxt_pa    = {ent_ppn, vaddr[PAGE_BITS-1:0]};
            nxt_perm  = hit_mask;
            nxt_fault = hit_fault;
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            pa        <= '0;
            perm      <= '0;
            fault     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                pa    <= nxt_pa;
                perm  <= nxt_perm;
                fault <= nxt_fault;
            end
        end
    end

    pg_capture #(.VA_W(VA_W), .OFF_W(OFF_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (req_valid && capture_en && (nxt_fault != FLT_NONE)),
        .addr  (vaddr),
        .off_q (ior),
        .spc_q (isr)
    );

    assert_phys_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(phys_mode) |-> fault == 4'd0 && perm == 3'b111);
    assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (fault == 4'd1 || fault == 4'd2) |-> pa == '0 && perm == 3'b000);
    assert_ref_exec_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && fault == 4'd8 |-> perm[1:0] == 2'b00);
    assert_write_stripped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (fault == 4'd6 || fault == 4'd7) |-> !perm[1]);
    assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rsp_valid == $past(req_valid));
endmodule

// File: tb/sim_page_guard.sv
module sim_page_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, phys_mode, probe_mode, capture_en;
    logic [1:0]  acc_type, priv, ent_pl1, ent_pl2;
    logic [63:0] vaddr;
    logic        hit, ent_valid, ent_d, ent_b, ent_t;
    logic [19:0] ent_ppn;
    logic [2:0]  ent_type;
    logic        rsp_valid;
    logic [31:0] pa;
    logic [2:0]  perm;
    logic [3:0]  fault;
    logic [31:0] ior, isr;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_ior = '0, exp_isr = '0;

    always #4 clk = ~clk;

    page_guard u0 (.*);

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Independent model of the requirements.
    function automatic void model(output logic [31:0] m_pa, output logic [2:0] m_perm, output logic [3:0] m_flt);
        logic r, w, x;
        logic [2:0] req;
        m_pa = '0; m_perm = '0; m_flt = 4'd0;
        if (phys_mode) begin
            m_pa = vaddr[31:0]; m_perm = 3'b111; return;
        end
        if (!hit || !ent_valid) begin
            m_flt = probe_mode ? 4'd2 : 4'd1; return;
        end
        m_pa = {ent_ppn, vaddr[11:0]};
        r = priv <= ent_pl1;
        w = priv <= ent_pl2;
        x = (priv >= ent_pl2) && (priv <= ent_pl1);
        case (ent_type)
            3'd0: m_perm = {1'b0, 1'b0, r};
            3'd1: m_perm = {1'b0, w, r};
            3'd2: m_perm = {x, 1'b0, r};
            3'd3: m_perm = {x, w, r};
            default: m_perm = {x, 2'b00};
        endcase
        if (acc_type == 2'b00) return;
        req = (acc_type == 2'b01) ? 3'b001 : (acc_type == 2'b10) ? 3'b010 : 3'b100;
        if ((m_perm & req) == 0) begin
            m_flt = (acc_type == 2'b11) ? 4'd3 : m_perm[0] ? 4'd4 : 4'd5;
            return;
        end
        if (ent_t && acc_type != 2'b11) m_flt = 4'd8;
        else if (ent_b && acc_type == 2'b10) m_flt = 4'd7;
        else if (!ent_d && acc_type == 2'b10) m_flt = 4'd6;
        if (!ent_d || ent_b) m_perm[1] = 1'b0;
        if (ent_t) m_perm = m_perm & 3'b100;
    endfunction

    task automatic run(input string tag);
        logic [31:0] e_pa; logic [2:0] e_perm; logic [3:0] e_flt;
        model(e_pa, e_perm, e_flt);
        req_valid = 1'b1;
        if (e_flt != 0 && capture_en) begin
            exp_ior = vaddr[31:0]; exp_isr = vaddr[63:32];
        end
        @(negedge clk);
        check("R12", "rsp_valid", rsp_valid, 1);
        check(tag, "fault", fault, e_flt);
        check(tag, "perm", perm, e_perm);
        check(tag, "pa", pa, e_pa);
        check("R10", "ior", ior, exp_ior);
        check("R10", "isr", isr, exp_isr);
    endtask

    task automatic setup(input logic [1:0] a, input logic [1:0] p, input logic [1:0] l1, input logic [1:0] l2,
                         input logic [2:0] ty, input logic d, input logic b, input logic t);
        phys_mode = 0; probe_mode = 0; hit = 1; ent_valid = 1;
        acc_type = a; priv = p; ent_pl1 = l1; ent_pl2 = l2; ent_type = ty;
        ent_d = d; ent_b = b; ent_t = t;
        vaddr = {$urandom, $urandom}; ent_ppn = 20'($urandom);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; req_valid = 0; capture_en = 0;
        setup(2'b01, 0, 0, 0, 0, 1, 0, 0);
        repeat (3) @(negedge clk);
        check("R12", "reset rsp_valid", rsp_valid, 0);
        check("R10", "reset ior", ior, 0);
        check("R10", "reset isr", isr, 0);
        check("R12", "reset fault", fault, 0);
        rst_n = 1;
        @(negedge clk);
        check("R12", "idle rsp_valid", rsp_valid, 0);

        setup(2'b11, 0, 0, 3, 0, 0, 1, 1); phys_mode = 1; capture_en = 1; run("R1");
        setup(2'b11, 0, 3, 0, 3, 1, 0, 0); hit = 0; run("R2");
        setup(2'b01, 0, 3, 0, 1, 1, 0, 0); ent_valid = 0; run("R2");
        setup(2'b01, 0, 3, 3, 1, 1, 0, 0); hit = 0; probe_mode = 1; run("R11");
        setup(2'b10, 0, 3, 3, 3, 0, 1, 1); run("R8");
        setup(2'b10, 0, 3, 3, 3, 0, 1, 0); run("R8");
        setup(2'b10, 0, 3, 3, 3, 0, 0, 0); run("R8");
        setup(2'b00, 0, 3, 3, 3, 0, 1, 1); run("R6");
        setup(2'b11, 1, 2, 1, 2, 1, 0, 1); run("R9");
        setup(2'b01, 1, 3, 3, 1, 0, 0, 0); run("R9");
        setup(2'b11, 2, 3, 3, 3, 1, 0, 0); run("R7");
        setup(2'b11, 1, 1, 1, 6, 1, 0, 0); run("R4");
        setup(2'b10, 2, 3, 1, 1, 1, 0, 0); run("R7");
        setup(2'b10, 3, 2, 1, 1, 1, 0, 0); capture_en = 0; run("R7");
        setup(2'b01, 0, 0, 0, 5, 1, 0, 0); capture_en = 1; run("R5");
        setup(2'b01, 0, 3, 3, 0, 1, 0, 0); run("R3");
        req_valid = 0;
        @(negedge clk);
        check("R12", "rsp_valid after idle", rsp_valid, 0);

        for (int i = 0; i < 3000; i++) begin
            setup(2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 3'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom));
            phys_mode = ($urandom % 10) == 0;
            probe_mode = 1'($urandom);
            hit = ($urandom % 8) != 0;
            ent_valid = ($urandom % 8) != 0;
            capture_en = 1'($urandom);
            run("R5");
            if (($urandom % 16) == 0) begin
                req_valid = 0;
                @(negedge clk);
                check("R12", "rsp_valid gap", rsp_valid, 0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule